// File: doc/BRIEF.md
# Cyclic ADC Sequencer with Redundancy Correction

This block is the digital controller for a recirculating analog-to-digital converter. The converter has two 1.5-bit stages that hand the residue back and forth. On a start request the block runs a fixed schedule of eight clock phases. In phase 1 the front end turns the selected single-ended input into a differential signal. The two stages then take turns sampling and amplifying, and from phase 3 on the second stage's residue is fed back into the first stage.

Each time a stage samples, the block latches that stage's two-bit thermometer comparator word as a digit of value 0, 1 or 2. It presents that digit as the stage's reference select for the following amplify phase. It also folds the digit into a shift-and-add accumulator, which removes the overlap between the redundant digits. The corrected code is published together with a one-cycle valid pulse.

The block also owns input channel selection through one-hot multiplexer enables, and it owns the low-power state. In the low-power state the analog bias enable and the clock enable for its own registers are both dropped. The block only enters or leaves that state between conversions.

Top module: `cadc_seq`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, bias_en and clk_en are 1, mux_en is 4'b0001, code is 0, and code_vld and every phase strobe are 0.
- R2: A start seen at a clock edge while idle and not asked to sleep makes the next eight cycles phases 1 to 8. s2d_en is high in phase 1 only. samp_b is high in phases 2, 4, 6 and 8. samp_a and xfer_b are high in phases 3, 5 and 7. xfer_a is high in phases 4, 6 and 8. All strobes are low outside a conversion.
- R3: A comparator word is decoded as 00 = 0, 01 = 1, 11 = 2, and the illegal word 10 = 1. Only the word of the stage whose sample strobe is high is captured, at the edge that ends that phase.
- R4: During a stage's amplify phase, its reference select (dac_a or dac_b) holds the digit captured at the end of that stage's previous sample phase, encoded 2'b00, 2'b01 or 2'b10.
- R5: With d0 the digit captured in phase 2 and d6 the digit captured in phase 8, code equals min(255, 1 + sum of dk * 2^(6-k)). All-2 digits give 8'hFF and all-0 digits give 8'h01.
- R6: code_vld is high for exactly the one cycle after phase 8. In that cycle code shows the new result, and code holds it until the next result.
- R7: Driven by an ideal residue model with comparator thresholds at 3/8 and 5/8 of full scale, code is within one count of floor(256 x input/full scale).
- R8: start is ignored during every phase of a conversion, including phase 8. The cycle after phase 8 is always idle.
- R9: mux_en is one-hot with bit i set for channel i, loaded from chan when a start is accepted. Changes on chan at any other time have no effect.
- R10: A sleep request takes effect only at an idle edge, and it wins over a simultaneous start. bias_en and clk_en are 0 from the next cycle. A conversion already running finishes first.
- R11: While asleep, code, mux_en, dac_a and dac_b hold their values, code_vld and all strobes stay 0, and start is ignored.
- R12: The cycle after sleep_req falls, bias_en and clk_en return to 1. A start in that one wake cycle is ignored, and a start is next accepted in the idle cycle that follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Conversion request |
| chan | input | 2 | Channel number, loaded on an accepted start |
| sleep_req | input | 1 | Low-power request |
| cmp_a | input | 2 | First stage comparator thermometer word |
| cmp_b | input | 2 | Second stage comparator thermometer word |
| s2d_en | output | 1 | Single-to-differential front end strobe (phase 1) |
| samp_a | output | 1 | First stage sample strobe |
| samp_b | output | 1 | Second stage sample strobe |
| xfer_a | output | 1 | First stage amplify strobe |
| xfer_b | output | 1 | Second stage amplify strobe |
| mux_en | output | 4 | One-hot input multiplexer enables |
| bias_en | output | 1 | Analog bias enable |
| clk_en | output | 1 | Clock enable for the block's own registers |
| dac_a | output | 2 | First stage reference select |
| dac_b | output | 2 | Second stage reference select |
| code | output | 8 | Corrected conversion result |
| code_vld | output | 1 | One-cycle result valid pulse |

## Verification
A phase counter that slips shows up at once in the strobe pattern. It also shifts code_vld away from the ninth cycle after the start, and the bench checks both on every cycle of every conversion. A wrong digit or a wrong alignment in the accumulator cannot hide. Its reference select is checked in the very next phase, and the final code is compared both with the exact digit sum and with the ideal input level one cycle after phase 8. Power-state errors appear as a change on code, mux_en or the reference selects while clk_en is low, or as a start taken during the wake cycle, and both are checked cycle by cycle.

// File: rtl/cadc_pkg.sv
`timescale 1ns/1ps
package cadc_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_CONV  = 2'd1,
      ST_SLEEP = 2'd2,
      ST_WAKE  = 2'd3
   } cadc_st_e;

   // thermometer word to digit value; the illegal word 10 reads as mid-scale
   function automatic logic [1:0] therm_digit(input logic [1:0] w);
      logic [1:0] d;
      case (w)
         2'b00:   d = 2'd0;
         2'b11:   d = 2'd2;
         default: d = 2'd1;
      endcase
      return d;
   endfunction

endpackage

// File: rtl/cadc_timer.sv
`timescale 1ns/1ps
module cadc_timer
   import cadc_pkg::*;
#(
   parameter int NPH = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic sleep_req,
   output logic awake,
   output logic start_acc,
   output logic first_cap,
   output logic last_ph,
   output logic s2d_en,
   output logic samp_a,
   output logic samp_b,
   output logic xfer_a,
   output logic xfer_b
);

   localparam int PH_W = $clog2(NPH);
   localparam logic [PH_W-1:0] PH_LAST = PH_W'(NPH - 1);

   cadc_st_e        st_q;
   logic [PH_W-1:0] ph_q;
   logic            conv;

   assign conv      = (st_q == ST_CONV);
   assign awake     = (st_q != ST_SLEEP);
   assign start_acc = (st_q == ST_IDLE) && start && !sleep_req;

   // always-on state register; it alone watches sleep_req while asleep
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q <= ST_IDLE;
         ph_q <= '0;
      end else begin
         case (st_q)
            ST_IDLE: begin
               if (sleep_req) begin
                  st_q <= ST_SLEEP;
               end else if (start) begin
                  st_q <= ST_CONV;
                  ph_q <= '0;
               end
            end
            ST_CONV: begin
               if (ph_q == PH_LAST) st_q <= ST_IDLE;
               else                 ph_q <= ph_q + 1'b1;
            end
            ST_SLEEP: begin
               if (!sleep_req) st_q <= ST_WAKE;
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   // ph_q = phase number - 1, so odd ph_q is an even phase
   assign s2d_en    = conv && (ph_q == '0);
   assign samp_b    = conv && ph_q[0];
   assign samp_a    = conv && !ph_q[0] && (ph_q != '0);
   assign xfer_b    = conv && !ph_q[0] && (ph_q != '0);
   assign xfer_a    = conv && ph_q[0] && (ph_q != PH_W'(1));
   assign first_cap = conv && (ph_q == PH_W'(1));
   assign last_ph   = conv && (ph_q == PH_LAST);

endmodule

// File: rtl/cadc_chsel.sv
`timescale 1ns/1ps
module cadc_chsel #(
   parameter int N_CH = 4
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       en,
   input  logic                       load,
   input  logic [$clog2(N_CH)-1:0]    chan,
   output logic [N_CH-1:0]            mux_en
);

   localparam int CH_W = $clog2(N_CH);

   logic [CH_W-1:0] sel_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            sel_q <= '0;
      else if (en && load)   sel_q <= chan;
   end

   for (genvar i = 0; i < N_CH; i++) begin : g_dec
      assign mux_en[i] = (sel_q == CH_W'(i));
   end

endmodule

// File: rtl/cadc_corr.sv
`timescale 1ns/1ps
module cadc_corr
   import cadc_pkg::*;
#(
   parameter int RES_BITS = 8,
   parameter int OFFSET   = 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                en,
   input  logic                cap_a,
   input  logic                cap_b,
   input  logic                first,
   input  logic                last,
   input  logic [1:0]          cmp_a,
   input  logic [1:0]          cmp_b,
   output logic [1:0]          dac_a,
   output logic [1:0]          dac_b,
   output logic [RES_BITS-1:0] code,
   output logic                code_vld
);

   localparam int ACC_W = RES_BITS;
   localparam int TOT_W = RES_BITS + 2;
   localparam logic [TOT_W-1:0] MAXC = TOT_W'((1 << RES_BITS) - 1);

   logic [1:0]          dig;
   logic [ACC_W-1:0]    acc_q;
   logic [ACC_W-1:0]    acc_nx;
   logic [RES_BITS-1:0] code_nx;

   assign dig    = cap_a ? therm_digit(cmp_a) : therm_digit(cmp_b);
   // each new digit lands one place lower; overlap bits are simply added
   assign acc_nx = first ? ACC_W'(dig) : ((acc_q << 1) + ACC_W'(dig));

   if (OFFSET == 0) begin : g_plain
      assign code_nx = acc_nx[RES_BITS-1:0];
   end else begin : g_sat
      logic [TOT_W-1:0] total;
      assign total   = TOT_W'(acc_nx) + TOT_W'(OFFSET);
      assign code_nx = (total > MAXC) ? MAXC[RES_BITS-1:0] : total[RES_BITS-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q    <= '0;
         dac_a    <= '0;
         dac_b    <= '0;
         code     <= '0;
         code_vld <= 1'b0;
      end else if (en) begin
         code_vld <= last;
         if (cap_a)          dac_a <= dig;
         if (cap_b)          dac_b <= dig;
         if (cap_a || cap_b) acc_q <= acc_nx;
         if (last)           code  <= code_nx;
      end
   end

endmodule

// File: rtl/cadc_seq.sv
`timescale 1ns/1ps
module cadc_seq #(
   parameter int RES_BITS = 8,
   parameter int N_CH     = 4,
   parameter int OFFSET   = 1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      start,
   input  logic [$clog2(N_CH)-1:0]   chan,
   input  logic                      sleep_req,
   input  logic [1:0]                cmp_a,
   input  logic [1:0]                cmp_b,
   output logic                      s2d_en,
   output logic                      samp_a,
   output logic                      samp_b,
   output logic                      xfer_a,
   output logic                      xfer_b,
   output logic [N_CH-1:0]           mux_en,
   output logic                      bias_en,
   output logic                      clk_en,
   output logic [1:0]                dac_a,
   output logic [1:0]                dac_b,
   output logic [RES_BITS-1:0]       code,
   output logic                      code_vld
);

   localparam int NPH = RES_BITS;

   if (RES_BITS < 4) begin : g_bad_res
      $error("cadc_seq: RES_BITS must be at least 4");
   end
   if (N_CH < 2 || (1 << $clog2(N_CH)) != N_CH) begin : g_bad_ch
      $error("cadc_seq: N_CH must be a power of two of at least 2");
   end
   if (OFFSET < 0) begin : g_bad_off
      $error("cadc_seq: OFFSET must not be negative");
   end

   logic awake;
   logic start_acc;
   logic first_cap;
   logic last_ph;

   cadc_timer #(.NPH(NPH)) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .sleep_req (sleep_req),
      .awake     (awake),
      .start_acc (start_acc),
      .first_cap (first_cap),
      .last_ph   (last_ph),
      .s2d_en    (s2d_en),
      .samp_a    (samp_a),
      .samp_b    (samp_b),
      .xfer_a    (xfer_a),
      .xfer_b    (xfer_b)
   );

   cadc_chsel #(.N_CH(N_CH)) u_chsel (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (awake),
      .load   (start_acc),
      .chan   (chan),
      .mux_en (mux_en)
   );

   cadc_corr #(.RES_BITS(RES_BITS), .OFFSET(OFFSET)) u_corr (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (awake),
      .cap_a    (samp_a),
      .cap_b    (samp_b),
      .first    (first_cap),
      .last     (last_ph),
      .cmp_a    (cmp_a),
      .cmp_b    (cmp_b),
      .dac_a    (dac_a),
      .dac_b    (dac_b),
      .code     (code),
      .code_vld (code_vld)
   );

   assign bias_en = awake;
   assign clk_en  = awake;

endmodule

// File: rtl/cadc_seq_chk.sv
`timescale 1ns/1ps
module cadc_seq_chk #(
   parameter int RES_BITS = 8,
   parameter int N_CH     = 4
) (
   input logic                clk,
   input logic                rst_n,
   input logic                sleep_req,
   input logic                s2d_en,
   input logic                samp_a,
   input logic                samp_b,
   input logic                xfer_a,
   input logic [N_CH-1:0]     mux_en,
   input logic                bias_en,
   input logic                clk_en,
   input logic [1:0]          dac_a,
   input logic [1:0]          dac_b,
   input logic [RES_BITS-1:0] code,
   input logic                code_vld
);

   p_strobe_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({s2d_en, samp_a, samp_b}));

   p_s2d_then_b_r2: assert property (@(posedge clk) disable iff (!rst_n)
      s2d_en |=> samp_b);

   p_dac_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (dac_a != 2'b11) && (dac_b != 2'b11));

   p_code_nonzero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      code_vld |-> (code != '0));

   p_vld_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
      code_vld |=> !code_vld);

   p_vld_after_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
      code_vld |-> ($past(samp_b) && $past(xfer_a) && !samp_b && !samp_a));

   p_mux_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(mux_en) == 1);

   p_mux_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !s2d_en |-> $stable(mux_en));

   p_sleep_entry_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(bias_en) |-> $past(sleep_req && !s2d_en && !samp_a && !samp_b));

   p_sleep_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !clk_en |-> ($stable(code) && $stable(dac_a) && $stable(dac_b) && !code_vld && !s2d_en && !samp_a && !samp_b));

   p_wake_gap_r12: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bias_en) |=> !s2d_en);

endmodule

bind cadc_seq cadc_seq_chk #(.RES_BITS(RES_BITS), .N_CH(N_CH)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .sleep_req (sleep_req),
   .s2d_en    (s2d_en),
   .samp_a    (samp_a),
   .samp_b    (samp_b),
   .xfer_a    (xfer_a),
   .mux_en    (mux_en),
   .bias_en   (bias_en),
   .clk_en    (clk_en),
   .dac_a     (dac_a),
   .dac_b     (dac_b),
   .code      (code),
   .code_vld  (code_vld)
);

// File: tb/sim_cadc_seq.sv
`timescale 1ns/1ps
module sim_cadc_seq;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0;
   logic [1:0] chan = 2'd0;
   logic       sleep_req = 1'b0;
   logic [1:0] cmp_a = 2'b00;
   logic [1:0] cmp_b = 2'b00;
   logic       s2d_en, samp_a, samp_b, xfer_a, xfer_b;
   logic [3:0] mux_en;
   logic       bias_en, clk_en;
   logic [1:0] dac_a, dac_b;
   logic [7:0] code;
   logic       code_vld;

   int n_chk = 0;
   int n_err = 0;
   int lvl [4];

   always #2.5 clk = ~clk;

   cadc_seq u0 (
      .clk (clk), .rst_n (rst_n), .start (start), .chan (chan),
      .sleep_req (sleep_req), .cmp_a (cmp_a), .cmp_b (cmp_b),
      .s2d_en (s2d_en), .samp_a (samp_a), .samp_b (samp_b),
      .xfer_a (xfer_a), .xfer_b (xfer_b), .mux_en (mux_en),
      .bias_en (bias_en), .clk_en (clk_en), .dac_a (dac_a), .dac_b (dac_b),
      .code (code), .code_vld (code_vld)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic logic [4:0] strobes();
      return {s2d_en, samp_a, samp_b, xfer_a, xfer_b};
   endfunction

   function automatic int digit_of(input int v);
      if (v < 24576) return 0;
      if (v < 40960) return 1;
      return 2;
   endfunction

   task automatic reset_state_check(input string tag);
      chk(bias_en && clk_en, {tag, " R1 power enables"}, {bias_en, clk_en}, 3);
      chk(mux_en == 4'b0001, {tag, " R1 mux_en"}, mux_en, 1);
      chk(code == 8'd0 && !code_vld, {tag, " R1 code/vld"}, {code, code_vld}, 0);
      chk(strobes() == 5'b0, {tag, " R1 strobes"}, strobes(), 0);
   endtask

   // one conversion from an idle negedge; leaves the bench at an idle negedge
   // (or asleep when slp_p is nonzero)
   task automatic convert(input int ch, input int x, input int inj_p, input int slp_p, input string rq);
      int dig [7];
      int cur, dprev, d, expc, diff;
      logic [1:0] w, dv;
      logic [4:0] ev;
      lvl[ch] = x;
      chan  = 2'(ch);
      start = 1'b1;
      @(negedge clk);
      chk(strobes() == 5'b10000, "R2 phase 1 strobes", strobes(), 16);
      chk(mux_en == 4'(1 << ch), "R9 mux_en at phase 1", mux_en, 1 << ch);
      cur = 0;
      for (int i = 0; i < 4; i++) if (mux_en[i]) cur = lvl[i];
      chan  = 2'(ch + 1);
      cmp_a = 2'($urandom);
      cmp_b = 2'($urandom);
      dprev = 0;
      for (int p = 2; p <= 8; p++) begin
         @(negedge clk);
         if (p == slp_p) sleep_req = 1'b1;
         ev = (p % 2 == 1) ? 5'b01001 : ((p >= 4) ? 5'b00110 : 5'b00100);
         chk(strobes() == ev, "R2 phase strobes", strobes(), ev);
         if (p >= 3) begin
            dv = (p % 2 == 1) ? dac_b : dac_a;
            chk(dv == 2'(dprev), "R4 reference select", dv, dprev);
            cur = 2 * cur - dprev * 32768;
         end
         d = digit_of(cur);
         dig[p-2] = d;
         w = (d == 0) ? 2'b00 : ((d == 1) ? 2'b01 : 2'b11);
         if (p == inj_p && d == 1) w = 2'b10;
         if (p % 2 == 0) begin cmp_b = w; cmp_a = 2'($urandom); end
         else            begin cmp_a = w; cmp_b = 2'($urandom); end
         dprev = d;
      end
      @(negedge clk);
      start = 1'b0;
      expc = 1;
      for (int k = 0; k < 7; k++) expc += dig[k] << (6 - k);
      if (expc > 255) expc = 255;
      chk(code_vld == 1'b1, "R6 valid after phase 8", code_vld, 1);
      chk(code == 8'(expc), rq, code, expc);
      diff = int'(code) - (x >> 8);
      chk(diff >= -1 && diff <= 1, "R7 code vs ideal level", code, x >> 8);
      chk(s2d_en == 1'b0, "R8 start held through conversion ignored", s2d_en, 0);
      chk(mux_en == 4'(1 << ch), "R9 chan change mid-conversion ignored", mux_en, 1 << ch);
      if (slp_p > 0) chk(bias_en == 1'b1, "R10 sleep waits for boundary", bias_en, 1);
      @(negedge clk);
      chk(code_vld == 1'b0 && code == 8'(expc), "R6 single pulse, code held", {code_vld, code}, expc);
      if (slp_p > 0)
         chk(!bias_en && !clk_en, "R10 asleep after boundary", {bias_en, clk_en}, 0);
      else
         chk(s2d_en == 1'b0, "R8 idle after conversion", s2d_en, 0);
   endtask

   task automatic wake_up();
      sleep_req = 1'b0;
      start = 1'b0;
      @(negedge clk);
      chk(bias_en && clk_en, "R12 enables back after wake", {bias_en, clk_en}, 3);
      start = 1'b1;
      @(negedge clk);
      chk(s2d_en == 1'b0, "R12 start in wake cycle ignored", s2d_en, 0);
      start = 1'b0;
      @(negedge clk);
      chk(s2d_en == 1'b0, "R12 still idle", s2d_en, 0);
   endtask

   task automatic sleep_idle(input int len);
      logic [7:0] c0;
      logic [3:0] m0;
      logic [3:0] d0;
      sleep_req = 1'b1;
      start = 1'b1;
      @(negedge clk);
      chk(!bias_en && !clk_en && !s2d_en, "R10 sleep wins over start", {bias_en, clk_en, s2d_en}, 0);
      c0 = code; m0 = mux_en; d0 = {dac_a, dac_b};
      for (int i = 0; i < len; i++) begin
         start = 1'($urandom);
         chan  = 2'($urandom);
         cmp_a = 2'($urandom);
         cmp_b = 2'($urandom);
         @(negedge clk);
         chk(code == c0 && mux_en == m0 && {dac_a, dac_b} == d0, "R11 state held asleep",
             {code, mux_en, dac_a, dac_b}, {c0, m0, d0});
         chk(!code_vld && strobes() == 5'b0, "R11 quiet asleep", {code_vld, strobes()}, 0);
      end
      wake_up();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      chk(1'b0, "watchdog expired", 0, 1);
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

   initial begin
      for (int i = 0; i < 4; i++) lvl[i] = 0;
      repeat (3) @(negedge clk);
      reset_state_check("in reset");
      rst_n = 1'b1;
      @(negedge clk);
      reset_state_check("after reset");

      convert(0, 0,     0, 0, "R5 all-zero digits give 1");
      convert(1, 65535, 0, 0, "R5 all-two digits give FF");
      convert(2, 24575, 0, 0, "R5 just below low threshold");
      convert(3, 24576, 0, 0, "R5 at low threshold");
      convert(0, 40959, 0, 0, "R5 just below high threshold");
      convert(1, 40960, 0, 0, "R5 at high threshold");

      for (int r = 0; r < 8; r++) begin
         for (int ch = 0; ch < 4; ch++) begin
            for (int i = 0; i < 4; i++) lvl[i] = int'($urandom % 65536);
            convert(ch, int'($urandom % 65536), 0, 0, "R5 corrected code");
         end
      end

      for (int i = 0; i < 8; i++) begin
         convert(i % 4, 24576 + int'($urandom % 16384), 2, 0, "R3 illegal word read as 1");
         convert((i + 1) % 4, int'($urandom % 65536), 2 + (i % 7), 0, "R3 illegal word later phase");
      end

      for (int i = 0; i < 6; i++) begin
         sleep_idle(4 + i);
         convert(i % 4, int'($urandom % 65536), 0, 0, "R5 conversion after wake");
         convert((i + 2) % 4, int'($urandom % 65536), 0, 3 + i, "R10 conversion with late sleep");
         wake_up();
         convert((i + 3) % 4, int'($urandom % 65536), 0, 0, "R12 conversion after wake");
      end

      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

endmodule